// File: doc/BRIEF.md
# Memory-Controller Event Counter Unit

This block counts traffic events inside a DRAM controller. Eight fixed-purpose 32-bit counters are each tied to one event source: write data beats, read data beats, write commands, read commands, precharge commands, activate commands, rank switches and read/write turnarounds. Each source arrives as a single-cycle pulse. Because every event owns its counter, there is no event-select register. Software reads a counter at that counter's own address.

Software reaches the unit through a plain 32-bit register port. A write strobe, an address and write data go in, and read data comes back combinationally for the address presented.

Counting is gated twice: by a global run bit, and by a per-counter enable bitmap. When a counter wraps, its overflow status bit is set. A write-one-to-clear register clears status bits one at a time, and a mask register (1 = masked) selects which status bits drive the level interrupt output.

Top module: `memctl_perf_counters`

## Requirements
- R1: After reset all counters read 0, the control, enable and status registers read 0, the mask register reads 0x000000FF, and `irq` is low.
- R2: Counters 0..7 are write data, read data, write command, read command, precharge, activate, rank switch and turnaround. They sit at offsets 0x380, 0x384, 0x388, 0x38C, 0x3C0, 0x3C4, 0x3CC and 0x3D0, and each can be written and read back as a full 32-bit value.
- R3: Counter n adds one on every clock where `evt_pulse[n]` is high, bit 1 of the control register (offset 0x010) is 1, and bit n of the enable register (offset 0x6C0) is 1. Otherwise it holds.
- R4: With control bit 1 cleared, no counter changes, whatever the pulses and enables.
- R5: A register write to counter n in the same clock as a counted pulse for n loads the written value, and that increment is lost.
- R6: A counter that steps from 0xFFFFFFFF to 0 sets bit n of the status register (offset 0x6CC).
- R7: Writing 1 to bit n of the clear register (offset 0x6D0) clears status bit n only. Other status bits are untouched, and a write to offset 0x6CC itself changes nothing.
- R8: If a wrap of counter n and a clear of status bit n fall in the same clock, the status bit ends up set.
- R9: `irq` is high exactly when some status bit n is 1 and bit n of the mask register (offset 0x6C8) is 0.
- R10: Reads of offsets that are not mapped return 0, as does the clear register. The control register stores only bit 1, and its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_pulse | input | 8 | One pulse per event source, bit n feeds counter n |
| irq | output | 1 | Level overflow interrupt |

## Verification
The hardest condition to reach from the ports is a counter wrap that lands in the same clock as a software clear of that counter's status bit, or as a software load of that counter. Both need a counter sitting one step below wrap at a known instant. The bench reaches it by preloading 0xFFFFFFFF or 0xFFFFFFFE through the register port and then driving the pulse and the conflicting write in one cycle. Around those cases it sweeps all 256 enable bitmaps and all 256 mask values, and predicts counts and interrupt level arithmetically.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
  parameter int NUM_CTR = 8;
  parameter int CTR_W   = 32;
  parameter int ADDR_W  = 12;
  parameter int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 12'h010;
  localparam logic [ADDR_W-1:0] ADR_EN   = 12'h6C0;
  localparam logic [ADDR_W-1:0] ADR_MASK = 12'h6C8;
  localparam logic [ADDR_W-1:0] ADR_STAT = 12'h6CC;
  localparam logic [ADDR_W-1:0] ADR_CLR  = 12'h6D0;
  localparam int RUN_BIT = 1;

  typedef enum logic [2:0] {
    EV_WR_DATA = 3'd0,
    EV_RD_DATA = 3'd1,
    EV_WR_CMD  = 3'd2,
    EV_RD_CMD  = 3'd3,
    EV_PRECHG  = 3'd4,
    EV_ACT     = 3'd5,
    EV_RANK_SW = 3'd6,
    EV_TURN    = 3'd7
  } evt_id_e;

  typedef logic [NUM_CTR-1:0] ctr_vec_t;

  function automatic logic [ADDR_W-1:0] ctr_addr(input int idx);
    case (evt_id_e'(idx[2:0]))
      EV_WR_DATA: ctr_addr = 12'h380;
      EV_RD_DATA: ctr_addr = 12'h384;
      EV_WR_CMD:  ctr_addr = 12'h388;
      EV_RD_CMD:  ctr_addr = 12'h38C;
      EV_PRECHG:  ctr_addr = 12'h3C0;
      EV_ACT:     ctr_addr = 12'h3C4;
      EV_RANK_SW: ctr_addr = 12'h3CC;
      default:    ctr_addr = 12'h3D0;
    endcase
  endfunction
endpackage

// File: rtl/mcp_reg_decode.sv
module mcp_reg_decode
  import mcp_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wen,
  output ctr_vec_t          ctr_hit,
  output ctr_vec_t          ctr_wr,
  output logic              ctrl_hit,
  output logic              en_hit,
  output logic              mask_hit,
  output logic              stat_hit,
  output logic              ctrl_wr,
  output logic              en_wr,
  output logic              mask_wr,
  output logic              clr_wr
);
  for (genvar g = 0; g < NUM_CTR; g++) begin : g_hit
    assign ctr_hit[g] = (addr == ctr_addr(g));
    assign ctr_wr[g]  = wen && ctr_hit[g];
  end

  assign ctrl_hit = (addr == ADR_CTRL);
  assign en_hit   = (addr == ADR_EN);
  assign mask_hit = (addr == ADR_MASK);
  assign stat_hit = (addr == ADR_STAT);

  assign ctrl_wr  = wen && ctrl_hit;
  assign en_wr    = wen && en_hit;
  assign mask_wr  = wen && mask_hit;
  assign clr_wr   = wen && (addr == ADR_CLR);
endmodule

// File: rtl/mcp_counter_slice.sv
module mcp_counter_slice #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic          cnt_ok,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          inc, ld;

  assign inc = evt && cnt_ok && !wr;
  assign ld  = wr || inc;

  always_comb begin
    cnt_d = cnt_q;
    if (wr)       cnt_d = wdata;
    else if (inc) cnt_d = cnt_q + CW'(1);
  end

  assign wrap = inc && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (ld) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && cnt_ok && !wr) |=> (cnt == $past(cnt) + CW'(1)));
  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(evt && cnt_ok) && !wr) |=> $stable(cnt));
  assert_load_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cnt == $past(wdata)));
endmodule

// File: rtl/mcp_ovf_status.sv
module mcp_ovf_status
  import mcp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ctr_vec_t wrap,
  input  logic     clr_wr,
  input  ctr_vec_t clr_bits,
  input  ctr_vec_t mask,
  output ctr_vec_t status,
  output logic     irq
);
  ctr_vec_t st_q, st_d, clr_vec;
  logic     st_en;

  assign clr_vec = clr_wr ? clr_bits : '0;
  assign st_d    = (st_q & ~clr_vec) | wrap;
  assign st_en   = clr_wr || (|wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  assign status = st_q;
  assign irq    = |(st_q & ~mask);

  assert_wrap_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap) |=> ((status & $past(wrap)) == $past(wrap)));
  assert_clear_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && |(clr_bits & ~wrap)) |=> ((status & $past(clr_bits & ~wrap)) == '0));
  assert_keep_others_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && (wrap == '0)) |=> ((status & ~$past(clr_bits)) == ($past(status) & ~$past(clr_bits))));
endmodule

// File: rtl/memctl_perf_counters.sv
module memctl_perf_counters
  import mcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_CTR-1:0] evt_pulse,
  output logic              irq
);
  ctr_vec_t ctr_hit, ctr_wr, wrap, status;
  logic     ctrl_hit, en_hit, mask_hit, stat_hit;
  logic     ctrl_wr, en_wr, mask_wr, clr_wr;

  logic     run_q, run_d;
  ctr_vec_t en_q, en_d, mask_q, mask_d;
  logic [CTR_W-1:0] cnt [NUM_CTR];

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  mcp_reg_decode u_dec (
    .addr(reg_addr), .wen(reg_wen),
    .ctr_hit(ctr_hit), .ctr_wr(ctr_wr),
    .ctrl_hit(ctrl_hit), .en_hit(en_hit), .mask_hit(mask_hit), .stat_hit(stat_hit),
    .ctrl_wr(ctrl_wr), .en_wr(en_wr), .mask_wr(mask_wr), .clr_wr(clr_wr)
  );

  // control registers: next state
  always_comb begin
    run_d  = ctrl_wr ? reg_wdata[RUN_BIT] : run_q;
    en_d   = en_wr   ? reg_wdata[NUM_CTR-1:0] : en_q;
    mask_d = mask_wr ? reg_wdata[NUM_CTR-1:0] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      en_q   <= '0;
      mask_q <= '1;
    end else begin
      if (ctrl_wr) run_q  <= run_d;
      if (en_wr)   en_q   <= en_d;
      if (mask_wr) mask_q <= mask_d;
    end
  end

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    mcp_counter_slice #(.CW(CTR_W)) u_slice (
      .clk(clk), .rst_n(rst_n),
      .evt(evt_pulse[g]),
      .cnt_ok(run_q && en_q[g]),
      .wr(ctr_wr[g]),
      .wdata(reg_wdata[CTR_W-1:0]),
      .cnt(cnt[g]),
      .wrap(wrap[g])
    );
  end

  mcp_ovf_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .wrap(wrap), .clr_wr(clr_wr), .clr_bits(reg_wdata[NUM_CTR-1:0]),
    .mask(mask_q), .status(status), .irq(irq)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (ctrl_hit) reg_rdata[RUN_BIT] = run_q;
    if (en_hit)   reg_rdata = DATA_W'(en_q);
    if (mask_hit) reg_rdata = DATA_W'(mask_q);
    if (stat_hit) reg_rdata = DATA_W'(status);
    for (int i = 0; i < NUM_CTR; i++) begin
      if (ctr_hit[i]) reg_rdata = DATA_W'(cnt[i]);
    end
  end

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq);
  assert_decode_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctr_hit, ctrl_hit, en_hit, mask_hit, stat_hit}));
endmodule

// File: tb/test_memctl_perf_counters.sv
module test_memctl_perf_counters;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  evt_pulse = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  memctl_perf_counters i_memctl_perf_counters (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse), .irq(irq)
  );

  function automatic logic [11:0] caddr(input int i);
    case (i)
      0: caddr = 12'h380; 1: caddr = 12'h384; 2: caddr = 12'h388; 3: caddr = 12'h38C;
      4: caddr = 12'h3C0; 5: caddr = 12'h3C4; 6: caddr = 12'h3CC; default: caddr = 12'h3D0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [11:0] a, input logic [31:0] d, input logic [7:0] e);
    @(negedge clk);
    reg_wen = we; reg_addr = a; reg_wdata = d; evt_pulse = e;
    @(negedge clk);
    reg_wen = 1'b0; evt_pulse = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 8'h00);
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic irq_chk(input string req, input logic exp);
    #1;
    chk(req, {31'b0, irq}, {31'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] base [8];
    logic [7:0]  st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 8; i++) rd_chk("R1 counter", caddr(i), 32'h0);
    rd_chk("R1 ctrl", 12'h010, 32'h0);
    rd_chk("R1 enable", 12'h6C0, 32'h0);
    rd_chk("R1 mask", 12'h6C8, 32'hFF);
    rd_chk("R1 status", 12'h6CC, 32'h0);
    irq_chk("R1 irq", 1'b0);

    // R2 preload and readback
    for (int i = 0; i < 8; i++) wr(caddr(i), 32'hA5C3_0000 ^ (32'h1111_1111 * i));
    for (int i = 0; i < 8; i++) rd_chk("R2 readback", caddr(i), 32'hA5C3_0000 ^ (32'h1111_1111 * i));

    // R10 unmapped and control width
    rd_chk("R10 gap 0x000", 12'h000, 32'h0);
    rd_chk("R10 gap 0x390", 12'h390, 32'h0);
    rd_chk("R10 gap 0x3C8", 12'h3C8, 32'h0);
    rd_chk("R10 gap 0x6C4", 12'h6C4, 32'h0);
    rd_chk("R10 clear reg", 12'h6D0, 32'h0);
    rd_chk("R10 gap 0xFFC", 12'hFFC, 32'h0);
    wr(12'h010, 32'hFFFF_FFFD);
    rd_chk("R10 ctrl bit1 clear", 12'h010, 32'h0);
    wr(12'h010, 32'hFFFF_FFFF);
    rd_chk("R10 ctrl only bit1", 12'h010, 32'h2);

    // R3 sweep over all enable bitmaps
    for (int p = 0; p < 256; p++) begin
      logic [7:0] e;
      int k;
      e = p[7:0] ^ 8'h5A;
      k = (p % 3) + 1;
      for (int i = 0; i < 8; i++) begin
        base[i] = (32'(p) << 16) | (32'(i) << 8);
        wr(caddr(i), base[i]);
      end
      wr(12'h6C0, 32'(p));
      for (int j = 0; j < k; j++) cyc(1'b0, 12'h000, 32'h0, e);
      for (int i = 0; i < 8; i++)
        rd_chk("R3 count", caddr(i), base[i] + ((p[i] && e[i]) ? 32'(k) : 32'h0));
    end

    // R4 global run off freezes everything
    wr(12'h6C0, 32'hFF);
    wr(12'h010, 32'h0);
    for (int i = 0; i < 8; i++) wr(caddr(i), 32'h100 + 32'(i));
    for (int j = 0; j < 4; j++) cyc(1'b0, 12'h000, 32'h0, 8'hFF);
    for (int i = 0; i < 8; i++) rd_chk("R4 frozen", caddr(i), 32'h100 + 32'(i));
    rd_chk("R1 status still clear", 12'h6CC, 32'h0);

    // R5 load collides with counted pulse
    wr(12'h010, 32'h2);
    cyc(1'b1, caddr(3), 32'h0000_1234, 8'hFF);
    rd_chk("R5 loaded value", caddr(3), 32'h0000_1234);
    rd_chk("R5 neighbour counted", caddr(2), 32'h103);

    // R6 wrap per counter, status accumulates, irq masked
    st = 8'h00;
    for (int i = 0; i < 8; i++) begin
      wr(caddr(i), 32'hFFFF_FFFE);
      wr(12'h6C0, 32'h1 << i);
      for (int j = 0; j < 3; j++) cyc(1'b0, 12'h000, 32'h0, 8'hFF);
      st[i] = 1'b1;
      rd_chk("R6 wrapped value", caddr(i), 32'h1);
      rd_chk("R6 status", 12'h6CC, 32'(st));
      irq_chk("R9 all masked", 1'b0);
    end

    // R7 writes to status offset do nothing; clear one bit at a time
    wr(12'h6C0, 32'h0);
    wr(12'h6CC, 32'h0);
    rd_chk("R7 status write ignored", 12'h6CC, 32'hFF);
    wr(12'h6D0, 32'h0);
    rd_chk("R7 zero clear ignored", 12'h6CC, 32'hFF);
    for (int i = 0; i < 8; i += 2) begin
      wr(12'h6D0, 32'h1 << i);
      st[i] = 1'b0;
      rd_chk("R7 single clear", 12'h6CC, 32'(st));
    end

    // R9 full mask sweep against status 0xAA
    for (int m = 0; m < 256; m++) begin
      wr(12'h6C8, 32'(m));
      irq_chk("R9 irq vs mask", |(st & ~m[7:0]));
    end

    // R8 wrap and clear of same bit in one cycle
    wr(12'h6C8, 32'hEF);
    wr(12'h6D0, 32'hFF);
    rd_chk("R7 clear all", 12'h6CC, 32'h0);
    irq_chk("R9 irq low after clear", 1'b0);
    wr(caddr(4), 32'hFFFF_FFFF);
    wr(12'h6C0, 32'h10);
    cyc(1'b1, 12'h6D0, 32'h10, 8'h10);
    rd_chk("R8 wrap beats clear", 12'h6CC, 32'h10);
    rd_chk("R6 counter at zero", caddr(4), 32'h0);
    irq_chk("R9 unmasked wrap", 1'b1);
    wr(12'h6D0, 32'h10);
    irq_chk("R9 irq drops", 1'b0);

    // R5 load at wrap point drops the wrap
    wr(caddr(4), 32'hFFFF_FFFF);
    cyc(1'b1, caddr(4), 32'h0000_0042, 8'h10);
    rd_chk("R5 load beats wrap value", caddr(4), 32'h42);
    rd_chk("R5 no status from dropped wrap", 12'h6CC, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule